// File: doc/BRIEF.md
# Four-Channel Coherent Single-Bin IQ Demodulator

This block extracts the complex amplitude of one known intermediate-frequency tone from four sampled receiver channels at the same time. A numerically controlled oscillator produces the sine and cosine references. Every channel is multiplied by the same two references, so the four channels stay phase-coherent with each other. The in-phase and quadrature products are summed over a measurement window, and at the end of the window each sum is scaled to the mean value. The result is one bin of a discrete Fourier transform per channel, ready for ratioing and calibration further downstream.

A measurement point works as follows. The controller sets a frequency tuning word and a window length, written as the base-2 logarithm of the sample count, and then pulses the start input. The block takes samples only on cycles where the sample-valid input is high. After the last sample of the window, it pulses a result-valid output that carries eight averaged values. A longer window gives a narrower effective IF bandwidth. For example, at a 40 MHz sample rate a window of about 4 million samples (0.1 s) corresponds to roughly a 10 Hz bandwidth.

Top module: `iqd_demod`

## Requirements
- R1: After reset, the window is closed, `res_valid_o` is low, and every result output is zero.
- R2: A start pulse while the window is closed opens it at that clock edge. The same edge latches `ftw_i` and `win_log2_i` (values above 24 are treated as 24) and clears the oscillator phase. A start pulse while the window is open has no effect on the running measurement.
- R3: Only cycles with `smp_valid_i` high while the window is open are accepted and counted. The window closes on the edge that accepts sample number 2^L, where L is the latched length.
- R4: The n-th accepted sample of a window (counting from 0) uses phase p = n·FTW mod 2^32 and index k = p[31:26]. The references are sine = round(2047·sin(2π(k+0.5)/64)) and cosine = round(2047·cos(2π(k+0.5)/64)), rounding half away from zero. At k = 0 the cosine is 2045 and the sine is 100.
- R5: Channel c takes its sample as a signed 12-bit value from `smp_data_i[12c+11:12c]`. Its results appear at `res_i_o[24c+23:24c]` (sum of sample·cosine) and `res_q_o[24c+23:24c]` (sum of sample·sine).
- R6: Each reported value is the window sum shifted arithmetically right by L, which is the floor of the sum divided by 2^L, truncated to 24 bits.
- R7: `res_valid_o` is high for exactly one cycle. It rises with the second clock edge after the edge that accepts the final sample. The result outputs hold their values until the next result.
- R8: Each window starts from cleared sums and zero phase, so two windows with the same settings and the same accepted samples report identical results, even when a new window starts on the edge right after the previous one closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a measurement window when none is running |
| ftw_i | input | 32 | Frequency tuning word (phase step per accepted sample) |
| win_log2_i | input | 5 | Base-2 log of the window sample count, limited to 24 |
| smp_valid_i | input | 1 | Marks a cycle that carries four new samples |
| smp_data_i | input | 48 | Four signed 12-bit samples, channel 0 in the low bits |
| res_valid_o | output | 1 | One-cycle pulse when the results are updated |
| res_i_o | output | 96 | Four signed 24-bit averaged in-phase values |
| res_q_o | output | 96 | Four signed 24-bit averaged quadrature values |

## Verification
A result is due two clock edges after the edge that accepts the final sample of a window. No output moves at any other time. The bench model advances on every rising edge from the same inputs the design sees. It tags each finished window with the edge number at which its result is due, and compares valid, I and Q at the following falling edge. On cycles without a due result, the bench checks that valid is low and that the previous values are still held. Directed windows add hand-derived values for phase zero, a negative sum that needs floor rounding, a start pulse mid-window, repeated windows, and windows of one sample started back to back.

// File: rtl/iqd_pkg.sv
package iqd_pkg;

    localparam int SMP_W     = 12;
    localparam int REF_W     = 12;
    localparam int PROD_W    = SMP_W + REF_W;
    localparam int RES_W     = PROD_W;
    localparam int PH_W      = 32;
    localparam int QTR_BITS  = 4;
    localparam int CIRC_BITS = QTR_BITS + 2;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [REF_W-1:0]  ref_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic        [PH_W-1:0]   phase_t;

    typedef struct packed {
        ref_t cos_v;
        ref_t sin_v;
    } ref_pair_t;

    typedef struct packed {
        prod_t i_v;
        prod_t q_v;
    } prod_pair_t;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_st_t;

    // First quadrant magnitudes at half-step offsets of a 64-point circle.
    function automatic ref_t qtr_mag(input logic [QTR_BITS-1:0] j);
        ref_t m;
        case (j)
            4'd0:    m = 12'sd100;
            4'd1:    m = 12'sd300;
            4'd2:    m = 12'sd497;
            4'd3:    m = 12'sd690;
            4'd4:    m = 12'sd875;
            4'd5:    m = 12'sd1052;
            4'd6:    m = 12'sd1219;
            4'd7:    m = 12'sd1375;
            4'd8:    m = 12'sd1517;
            4'd9:    m = 12'sd1644;
            4'd10:   m = 12'sd1756;
            4'd11:   m = 12'sd1850;
            4'd12:   m = 12'sd1927;
            4'd13:   m = 12'sd1986;
            4'd14:   m = 12'sd2025;
            4'd15:   m = 12'sd2045;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Full-circle sine built from the quadrant table by mirror and sign.
    function automatic ref_t sine_at(input logic [CIRC_BITS-1:0] k);
        logic [QTR_BITS-1:0] j;
        ref_t                m;
        j = k[QTR_BITS] ? ~k[QTR_BITS-1:0] : k[QTR_BITS-1:0];
        m = qtr_mag(j);
        return k[CIRC_BITS-1] ? -m : m;
    endfunction

    // Cosine is the sine a quarter turn further on.
    function automatic ref_pair_t ref_lookup(input logic [CIRC_BITS-1:0] k);
        ref_pair_t r;
        r.sin_v = sine_at(k);
        r.cos_v = sine_at(k + (CIRC_BITS'(1) << QTR_BITS));
        return r;
    endfunction

endpackage

// File: rtl/iqd_nco.sv
module iqd_nco
    import iqd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart_i,
    input  logic      step_i,
    input  phase_t    ftw_i,
    output ref_pair_t ref_o
);

    phase_t    phase_q;
    ref_pair_t ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            ref_q   <= '0;
        end else if (restart_i) begin
            phase_q <= '0;
        end else if (step_i) begin
            ref_q   <= ref_lookup(phase_q[PH_W-1 -: CIRC_BITS]);
            phase_q <= phase_q + ftw_i;
        end
    end

    assign ref_o = ref_q;

    // R2: a window always begins at phase zero
    a_r2_phase_cleared: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (phase_q == '0));

    // R4: the reference pair only moves when a sample is taken
    a_r4_ref_held: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !restart_i) |=> $stable(ref_q));

endmodule

// File: rtl/iqd_ctrl.sv
module iqd_ctrl
    import iqd_pkg::*;
#(
    parameter int MAX_LOG2 = 24,
    parameter int LOG_W    = $clog2(MAX_LOG2 + 1),
    parameter int CNT_W    = MAX_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             smp_valid_i,
    input  phase_t           ftw_i,
    input  logic [LOG_W-1:0] log2_i,
    output logic             restart_o,
    output logic             accept_o,
    output logic             mix_en_o,
    output logic             acc_en_o,
    output logic             final_o,
    output logic [LOG_W-1:0] shift_o,
    output phase_t           ftw_o,
    output logic             res_valid_o
);

    win_st_t          st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_m1;
    logic [LOG_W-1:0] log2_q;
    logic [LOG_W-1:0] log2_lim;
    logic [LOG_W-1:0] shift_q;
    phase_t           ftw_q;
    logic             acc_now;
    logic             last_now;
    logic             va_q, la_q, vb_q, lb_q, rv_q;

    assign log2_lim = (int'(log2_i) > MAX_LOG2) ? LOG_W'(MAX_LOG2) : log2_i;
    assign len_m1   = (CNT_W'(1) << log2_q) - CNT_W'(1);
    assign restart_o = (st_q == WIN_IDLE) && start_i;
    assign acc_now   = (st_q == WIN_OPEN) && smp_valid_i;
    assign last_now  = acc_now && (cnt_q == len_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= WIN_IDLE;
            cnt_q   <= '0;
            log2_q  <= '0;
            shift_q <= '0;
            ftw_q   <= '0;
            va_q    <= 1'b0;
            la_q    <= 1'b0;
            vb_q    <= 1'b0;
            lb_q    <= 1'b0;
            rv_q    <= 1'b0;
        end else begin
            va_q <= acc_now;
            la_q <= last_now;
            vb_q <= va_q;
            lb_q <= la_q;
            rv_q <= lb_q;
            if (restart_o) begin
                st_q   <= WIN_OPEN;
                cnt_q  <= '0;
                ftw_q  <= ftw_i;
                log2_q <= log2_lim;
            end else if (acc_now) begin
                if (last_now) begin
                    st_q    <= WIN_IDLE;
                    cnt_q   <= '0;
                    shift_q <= log2_q;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    assign accept_o    = acc_now;
    assign mix_en_o    = va_q;
    assign acc_en_o    = vb_q;
    assign final_o     = lb_q;
    assign shift_o     = shift_q;
    assign ftw_o       = ftw_q;
    assign res_valid_o = rv_q;

    // R7: a result strobe never lasts more than one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rv_q |=> !rv_q);

    // R3: the sample count stays inside the latched window length
    a_r3_count_in_window: assert property (@(posedge clk) disable iff (rst)
        (st_q == WIN_OPEN) |-> (cnt_q <= len_m1));

    // R2: settings of a running window cannot be replaced
    a_r2_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        (st_q == WIN_OPEN) |=> ($stable(ftw_q) && $stable(log2_q)));

endmodule

// File: rtl/iqd_lane.sv
module iqd_lane
    import iqd_pkg::*;
#(
    parameter int ACC_W = 48,
    parameter int LOG_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic             mix_i,
    input  logic             acc_en_i,
    input  logic             final_i,
    input  logic [LOG_W-1:0] shift_i,
    input  smp_t             smp_i,
    input  ref_pair_t        ref_i,
    output prod_t            res_i_o,
    output prod_t            res_q_o
);

    smp_t                    smp_q;
    prod_pair_t              prod_q;
    logic signed [ACC_W-1:0] acc_i_q, acc_q_q;
    logic signed [ACC_W-1:0] ext_i, ext_q;
    logic signed [ACC_W-1:0] sum_i, sum_q;
    logic signed [ACC_W-1:0] avg_i, avg_q;
    prod_t                   res_i_q, res_q_q;

    always_comb begin
        ext_i = {{(ACC_W-PROD_W){prod_q.i_v[PROD_W-1]}}, prod_q.i_v};
        ext_q = {{(ACC_W-PROD_W){prod_q.q_v[PROD_W-1]}}, prod_q.q_v};
        sum_i = acc_i_q + ext_i;
        sum_q = acc_q_q + ext_q;
        avg_i = sum_i >>> shift_i;
        avg_q = sum_q >>> shift_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q   <= '0;
            prod_q  <= '0;
            acc_i_q <= '0;
            acc_q_q <= '0;
            res_i_q <= '0;
            res_q_q <= '0;
        end else begin
            if (capture_i) begin
                smp_q <= smp_i;
            end
            if (mix_i) begin
                prod_q.i_v <= smp_q * ref_i.cos_v;
                prod_q.q_v <= smp_q * ref_i.sin_v;
            end
            if (acc_en_i) begin
                if (final_i) begin
                    res_i_q <= avg_i[RES_W-1:0];
                    res_q_q <= avg_q[RES_W-1:0];
                    acc_i_q <= '0;
                    acc_q_q <= '0;
                end else begin
                    acc_i_q <= sum_i;
                    acc_q_q <= sum_q;
                end
            end
        end
    end

    assign res_i_o = res_i_q;
    assign res_q_o = res_q_q;

    // R8: sums start from zero after every window
    a_r8_acc_cleared: assert property (@(posedge clk) disable iff (rst)
        (acc_en_i && final_i) |=> (acc_i_q == '0 && acc_q_q == '0));

    // R5: the running sums never wrap
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        acc_en_i |-> !(((acc_i_q[ACC_W-1] == ext_i[ACC_W-1]) && (sum_i[ACC_W-1] != acc_i_q[ACC_W-1])) ||
                       ((acc_q_q[ACC_W-1] == ext_q[ACC_W-1]) && (sum_q[ACC_W-1] != acc_q_q[ACC_W-1]))));

    // R7: results only change on a closing accumulation
    a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
        !(acc_en_i && final_i) |=> ($stable(res_i_q) && $stable(res_q_q)));

endmodule

// File: rtl/iqd_demod.sv
module iqd_demod
    import iqd_pkg::*;
#(
    parameter int CH       = 4,
    parameter int MAX_LOG2 = 24
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_i,
    input  logic [PH_W-1:0]                   ftw_i,
    input  logic [$clog2(MAX_LOG2+1)-1:0]     win_log2_i,
    input  logic                              smp_valid_i,
    input  logic [CH*SMP_W-1:0]               smp_data_i,
    output logic                              res_valid_o,
    output logic [CH*RES_W-1:0]               res_i_o,
    output logic [CH*RES_W-1:0]               res_q_o
);

    localparam int LOG_W = $clog2(MAX_LOG2 + 1);
    localparam int CNT_W = MAX_LOG2 + 1;
    localparam int ACC_W = PROD_W + MAX_LOG2;

    logic             restart, accept, mix_en, acc_en, fin;
    logic [LOG_W-1:0] shift;
    phase_t           ftw_run;
    ref_pair_t        ref_pair;

    iqd_ctrl #(
        .MAX_LOG2 (MAX_LOG2),
        .LOG_W    (LOG_W),
        .CNT_W    (CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .smp_valid_i (smp_valid_i),
        .ftw_i       (ftw_i),
        .log2_i      (win_log2_i),
        .restart_o   (restart),
        .accept_o    (accept),
        .mix_en_o    (mix_en),
        .acc_en_o    (acc_en),
        .final_o     (fin),
        .shift_o     (shift),
        .ftw_o       (ftw_run),
        .res_valid_o (res_valid_o)
    );

    iqd_nco u_nco (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .step_i    (accept),
        .ftw_i     (ftw_run),
        .ref_o     (ref_pair)
    );

    for (genvar c = 0; c < CH; c++) begin : g_lane
        prod_t li, lq;

        iqd_lane #(
            .ACC_W (ACC_W),
            .LOG_W (LOG_W)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .capture_i (accept),
            .mix_i     (mix_en),
            .acc_en_i  (acc_en),
            .final_i   (fin),
            .shift_i   (shift),
            .smp_i     (smp_data_i[c*SMP_W +: SMP_W]),
            .ref_i     (ref_pair),
            .res_i_o   (li),
            .res_q_o   (lq)
        );

        assign res_i_o[c*RES_W +: RES_W] = li;
        assign res_q_o[c*RES_W +: RES_W] = lq;
    end

endmodule

// File: tb/tb_iqd_demod.sv
`timescale 1ns/1ps
module tb_iqd_demod;

    localparam int  CH = 4;
    localparam real PI = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] ftw = '0;
    logic [4:0]  win_log2 = '0;
    logic        smp_valid = 1'b0;
    logic [47:0] smp_data = '0;
    logic        res_valid;
    logic [95:0] res_i, res_q;

    iqd_demod dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .ftw_i       (ftw),
        .win_log2_i  (win_log2),
        .smp_valid_i (smp_valid),
        .smp_data_i  (smp_data),
        .res_valid_o (res_valid),
        .res_i_o     (res_i),
        .res_q_o     (res_q)
    );

    always #2.5 clk = ~clk;

    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;
    string       cur_tag = "R5";
    int          dc[CH];

    // reference model state
    int          ec = 0;
    bit          m_open = 0;
    longint      m_cnt = 0;
    int          m_log2 = 0;
    bit [31:0]   m_ph = 0, m_ftw = 0;
    longint      m_si[CH], m_sq[CH];
    int          due_q[$];
    logic [95:0] ei_q[$], eq_q[$];
    logic [95:0] hold_i = '0, hold_q = '0;
    logic [95:0] cap_i = '0, cap_q = '0;

    function automatic int rnd(real a);
        return (a >= 0.0) ? $rtoi(a + 0.5) : -$rtoi(-a + 0.5);
    endfunction

    function automatic int ref_sin(int k);
        return rnd(2047.0 * $sin(2.0 * PI * (real'(k) + 0.5) / 64.0));
    endfunction

    function automatic int ref_cos(int k);
        return rnd(2047.0 * $cos(2.0 * PI * (real'(k) + 0.5) / 64.0));
    endfunction

    function automatic logic [95:0] pack4(int a, int b, int c, int d);
        return {24'(d), 24'(c), 24'(b), 24'(a)};
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [95:0] act, logic [95:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        ec++;
        if (rst) begin
            m_open = 0;
            m_cnt  = 0;
            due_q.delete();
            ei_q.delete();
            eq_q.delete();
        end else if (!m_open) begin
            if (start) begin
                m_open = 1;
                m_cnt  = 0;
                m_ph   = 0;
                m_ftw  = ftw;
                m_log2 = (win_log2 > 5'd24) ? 24 : int'(win_log2);
                for (int c = 0; c < CH; c++) begin
                    m_si[c] = 0;
                    m_sq[c] = 0;
                end
            end
        end else if (smp_valid) begin
            int k;
            k = int'(m_ph[31:26]);
            for (int c = 0; c < CH; c++) begin
                int x;
                x = int'($signed(smp_data[c*12 +: 12]));
                m_si[c] += longint'(x * ref_cos(k));
                m_sq[c] += longint'(x * ref_sin(k));
            end
            m_ph  = m_ph + m_ftw;
            m_cnt = m_cnt + 1;
            if (m_cnt == (longint'(1) << m_log2)) begin
                logic [95:0] vi, vq;
                m_open = 0;
                for (int c = 0; c < CH; c++) begin
                    vi[c*24 +: 24] = 24'(m_si[c] >>> m_log2);
                    vq[c*24 +: 24] = 24'(m_sq[c] >>> m_log2);
                end
                due_q.push_back(ec + 2);
                ei_q.push_back(vi);
                eq_q.push_back(vq);
            end
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_v;
            exp_v = (due_q.size() > 0) && (due_q[0] == ec);
            chk(res_valid === exp_v, "R7", "result strobe", 96'(res_valid), 96'(exp_v));
            if (exp_v) begin
                hold_i = ei_q.pop_front();
                hold_q = eq_q.pop_front();
                void'(due_q.pop_front());
                chk(res_i === hold_i, cur_tag, "I results", res_i, hold_i);
                chk(res_q === hold_q, cur_tag, "Q results", res_q, hold_q);
            end else begin
                chk(res_i === hold_i && res_q === hold_q, "R7", "held results",
                    res_i ^ hold_i, res_q ^ hold_q);
            end
            if (res_valid) begin
                cap_i = res_i;
                cap_q = res_q;
            end
        end
    end

    function automatic logic [47:0] gen(int mode, int s, logic [31:0] f, int amp);
        logic [47:0] v;
        for (int c = 0; c < CH; c++) begin
            int x;
            case (mode)
                0: x = int'($signed(12'($urandom)));
                1: x = dc[c];
                2: begin
                    real ph;
                    ph = 2.0 * PI * real'(s) * real'(f) / 4294967296.0 + 0.9 * real'(c);
                    x  = rnd(real'(amp) * $cos(ph));
                    if (x > 2047) x = 2047;
                    if (x < -2048) x = -2048;
                end
                default: x = (s == 0) ? dc[c] : 0;
            endcase
            v[c*12 +: 12] = 12'(x);
        end
        return v;
    endfunction

    task automatic run_win(logic [31:0] f, int lg, int mode, int gap_pct, int amp,
                           int poke_at, int tail);
        int n;
        n = 1 << lg;
        @(negedge clk);
        start = 1; ftw = f; win_log2 = 5'(lg); smp_valid = 0;
        @(negedge clk);
        start = 0; ftw = $urandom; win_log2 = 5'($urandom);
        for (int s = 0; s < n; ) begin
            start = (s == poke_at) ? 1'b1 : 1'b0;
            if (gap_pct > 0 && int'($urandom % 100) < gap_pct) begin
                smp_valid = 0;
                smp_data  = 48'({$urandom, $urandom});
            end else begin
                smp_valid = 1;
                smp_data  = gen(mode, s, f, amp);
                s++;
            end
            @(negedge clk);
        end
        start = 0;
        smp_valid = 0;
        repeat (tail) @(negedge clk);
    endtask

    initial begin
        logic [95:0] ref_i, ref_q;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk(res_valid === 1'b0 && res_i === '0 && res_q === '0, "R1", "reset outputs",
            res_i | res_q | 96'(res_valid), '0);

        // R4: phase zero, constant inputs
        cur_tag = "R4";
        dc[0] = 1000; dc[1] = -2048; dc[2] = 0; dc[3] = 2047;
        run_win(32'h0, 2, 1, 0, 0, -1, 4);
        chk(cap_i === pack4(1000*2045, -2048*2045, 0, 2047*2045), "R4", "phase-zero I",
            cap_i, pack4(1000*2045, -2048*2045, 0, 2047*2045));
        chk(cap_q === pack4(1000*100, -2048*100, 0, 2047*100), "R4", "phase-zero Q",
            cap_q, pack4(1000*100, -2048*100, 0, 2047*100));

        // R6: floor on a negative odd sum
        cur_tag = "R6";
        dc[0] = -1; dc[1] = 1; dc[2] = 3; dc[3] = -3;
        run_win(32'h0, 1, 3, 0, 0, -1, 4);
        chk(cap_i === pack4(-1023, 1022, 3067, -3068), "R6", "floor shift I",
            cap_i, pack4(-1023, 1022, 3067, -3068));
        chk(cap_q === pack4(-50, 50, 150, -150), "R6", "floor shift Q",
            cap_q, pack4(-50, 50, 150, -150));

        // R5: random data, several lengths and frequencies
        cur_tag = "R5";
        run_win(32'h0CCC_CCCD, 0, 0, 0, 0, -1, 3);
        run_win(32'h1999_999A, 3, 0, 0, 0, -1, 3);
        run_win(32'h0A3D_70A4, 6, 0, 0, 0, -1, 3);
        run_win(32'hF123_4567, 10, 0, 0, 0, -1, 3);

        // R3: gaps in the valid stream
        cur_tag = "R3";
        run_win(32'h0800_0000, 5, 0, 40, 0, -1, 3);
        run_win(32'h1234_5678, 9, 2, 30, 1800, -1, 3);

        // R2 and R8: same tone twice, second run poked with start mid-window
        cur_tag = "R8";
        run_win(32'h0666_6666, 7, 2, 20, 2000, -1, 4);
        ref_i = cap_i; ref_q = cap_q;
        cur_tag = "R2";
        run_win(32'h0666_6666, 7, 2, 20, 2000, 64, 4);
        chk(cap_i === ref_i && cap_q === ref_q, "R2", "start ignored mid-window",
            cap_i ^ ref_i, cap_q ^ ref_q);
        cur_tag = "R8";
        run_win(32'h0666_6666, 7, 2, 0, 2000, -1, 4);
        chk(cap_i === ref_i && cap_q === ref_q, "R8", "repeat window",
            cap_i ^ ref_i, cap_q ^ ref_q);

        // R8: one-sample windows started back to back
        run_win(32'h2000_0000, 0, 0, 0, 0, -1, 0);
        run_win(32'h3000_0000, 1, 0, 0, 0, -1, 0);
        run_win(32'h4000_0000, 0, 0, 0, 0, -1, 4);

        // R6: long window of full-scale negative input
        cur_tag = "R6";
        dc[0] = -2048; dc[1] = -2048; dc[2] = 2047; dc[3] = -1;
        run_win(32'h0100_0000, 12, 1, 0, 0, -1, 4);

        repeat (4) @(negedge clk);
        chk(due_q.size() == 0, "R7", "no result outstanding", 96'(due_q.size()), '0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL R3 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule